// File: doc/BRIEF.md
# Dual-Clock Sample FIFO with Staggered Read Start

This block moves multi-bit samples from one clock domain to a second, unrelated clock domain. The producer pushes words with a write enable and watches a full flag. The consumer pops words with a read enable and watches an empty flag. Each side has its own active-low reset, asserted asynchronously and released in its own domain.

Each side keeps a binary pointer with one extra wrap bit, and a Gray-coded copy of it. Each Gray pointer crosses into the opposite domain through a flop chain of two or three stages. Storage is a plain register array indexed by the low pointer bits. Because the far pointer is seen late, full and empty are conservative. They may stay asserted a few cycles longer than strictly needed, but they never permit an overrun or an underrun.

After reset, the read side stays closed until the write side has left reset. A marker from the write domain must pass through the read synchronizer, and then a programmable count of read-clock cycles must elapse. During that whole window empty stays asserted. The two pointers therefore never start up in parallel.

Top module: `xclk_sample_fifo`

## Requirements
- R1: While the resets are held, full is 0, empty is 1 and the read data output is 0.
- R2: Words leave the read port in exactly the order in which they were accepted at the write port, with no loss and no duplication.
- R3: With no reads, exactly 2**ADDR_W writes are accepted (8 by default), and full is 1 from the sample after the last accepted write. The number of stored words never exceeds 2**ADDR_W.
- R4: A write presented while full is 1 is ignored. It stores nothing, and the write pointer does not move.
- R5: A read presented while empty is 1 is ignored. The read data output holds its value, and the next word written is the next word read.
- R6: Read data appears on the read-clock edge that accepts the read, so it is valid at the following sample. Empty is 0 whenever stored data has become visible to the read side.
- R7: When the write side is already out of reset, empty stays 1 for the first SYNC_STAGES+START_WAIT-1 read-clock edges after the read reset is released (4 by default). No read is accepted in that window. Empty can fall at edge SYNC_STAGES+START_WAIT (the 5th by default).
- R8: Each Gray pointer changes in at most one bit per clock of its own domain.
- R9: Once the FIFO is drained, empty returns to 1. After the read pointer has crossed back, full returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No space for another word |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Most recently read word |
| rd_empty | output | 1 | No word readable, or start-up window not over |

## Verification
On every clock, the embedded properties check that Gray pointers move by one bit, that a refused write or read leaves its pointer still, that the write side never runs more than one buffer ahead of the read pointer it sees, and that the read pointer stays at zero until the start-up window has closed. Only the bench scenarios can show data order under shifting duty cycles with unrelated clock periods, the exact edge at which empty first falls after the read reset, that a refused write leaves no trace in the data, and that the flags recover after the buffer is filled or drained.

// File: rtl/xclk_sample_fifo.sv
module xclk_sample_fifo #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int START_WAIT  = 3
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(START_WAIT + 1);

  function automatic logic [ADDR_W:0] gray2bin(input logic [ADDR_W:0] g);
    logic [ADDR_W:0] b;
    for (int i = 0; i <= ADDR_W; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [DATA_W-1:0] store [DEPTH];

  // write domain
  logic [ADDR_W:0] wbin, wgray, rgray_seen;
  logic [SYNC_STAGES-1:0][ADDR_W:0] rgray_chain;
  logic wr_live;
  logic wr_go;

  assign rgray_seen = rgray_chain[SYNC_STAGES-1];
  assign wr_full = (wgray == {~rgray_seen[ADDR_W:ADDR_W-1], rgray_seen[ADDR_W-2:0]});
  assign wr_go = wr_en && !wr_full;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin        <= '0;
      wgray       <= '0;
      rgray_chain <= '0;
      wr_live     <= 1'b0;
    end else begin
      wr_live     <= 1'b1;
      rgray_chain <= {rgray_chain[SYNC_STAGES-2:0], rgray};
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_go) store[wbin[ADDR_W-1:0]] <= wr_data;
  end

  // read domain
  logic [ADDR_W:0] rbin, rgray, wgray_seen;
  logic [SYNC_STAGES-1:0][ADDR_W:0] wgray_chain;
  logic [SYNC_STAGES-1:0] live_chain;
  logic [CNT_W-1:0] wait_cnt;
  logic rd_open;
  logic rd_go;

  assign wgray_seen = wgray_chain[SYNC_STAGES-1];
  assign rd_empty = !rd_open || (rgray == wgray_seen);
  assign rd_go = rd_en && !rd_empty;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin        <= '0;
      rgray       <= '0;
      wgray_chain <= '0;
      live_chain  <= '0;
      wait_cnt    <= '0;
      rd_open     <= 1'b0;
      rd_data     <= '0;
    end else begin
      wgray_chain <= {wgray_chain[SYNC_STAGES-2:0], wgray};
      live_chain  <= {live_chain[SYNC_STAGES-2:0], wr_live};
      if (live_chain[SYNC_STAGES-1] && !rd_open) begin
        wait_cnt <= wait_cnt + 1'b1;
        if (wait_cnt == CNT_W'(START_WAIT - 1)) rd_open <= 1'b1;
      end
      if (rd_go) begin
        rbin    <= rbin + 1'b1;
        rgray   <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
        rd_data <= store[rbin[ADDR_W-1:0]];
      end
    end
  end

  // embedded checks
  a_r8_wgray_one_bit: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r8_rgray_one_bit: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  a_r4_full_write_ignored: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> $stable(wbin));
  a_r5_empty_read_ignored: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> ($stable(rbin) && $stable(rd_data)));
  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wbin - gray2bin(rgray_seen)) <= (ADDR_W+1)'(DEPTH));
  a_r7_closed_until_start: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_open |-> (rbin == '0));

endmodule

// File: tb/xclk_sample_fifo_tb.sv
`timescale 1ns/1ps
module xclk_sample_fifo_tb;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int SYNC = 2;
  localparam int WAIT = 3;
  localparam int NS = 300;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_full, rd_empty;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] q[$];
  logic pending = 0;
  logic [DW-1:0] exp_word = '0;

  always #5 wr_clk = ~wr_clk;
  always #6.85 rd_clk = ~rd_clk;

  xclk_sample_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC), .START_WAIT(WAIT)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_try(input logic [DW-1:0] v, output logic acc);
    @(negedge wr_clk);
    wr_data = v;
    wr_en = 1;
    acc = !wr_full;
    if (acc) q.push_back(v);
  endtask

  task automatic wr_stop;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic rd_cmp;
    if (pending) check(rd_data == exp_word, "R2/R6 data order", rd_data, exp_word);
    pending = 0;
  endtask

  task automatic rd_try(output logic acc);
    @(negedge rd_clk);
    rd_cmp();
    rd_en = 1;
    acc = !rd_empty;
    if (acc) begin
      pending = 1;
      exp_word = q.pop_front();
    end
  endtask

  task automatic rd_stop;
    @(negedge rd_clk);
    rd_cmp();
    rd_en = 0;
  endtask

  initial begin
    forever begin
      @(posedge wr_clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic acc;
    logic [DW-1:0] held;
    #40;
    // R1 reset state
    check(wr_full == 0, "R1 full in reset", wr_full, 0);
    check(rd_empty == 1, "R1 empty in reset", rd_empty, 1);
    check(rd_data == 0, "R1 data in reset", rd_data, 0);

    // write side first, then read side (R7)
    @(negedge wr_clk) wr_rst_n = 1;
    wr_try(16'h1111, acc);
    check(acc == 1, "R3 write accepted after reset", acc, 1);
    wr_try(16'h2222, acc);
    wr_stop();
    repeat (10) @(negedge wr_clk);
    @(negedge rd_clk) rd_rst_n = 1;
    for (int k = 1; k <= SYNC + WAIT; k++) begin
      rd_try(acc);
      check(acc == (k == SYNC + WAIT), "R7 empty through start window", acc, k == SYNC + WAIT);
      if (k < SYNC + WAIT) check(rd_data == 0, "R7 no read during window", rd_data, 0);
    end
    rd_try(acc);
    rd_stop();
    check(q.size() == 0, "R2 startup words drained", q.size(), 0);

    // fill with no reads (R3, R4)
    repeat (4) @(negedge wr_clk);
    for (int i = 0; i < DEPTH; i++) begin
      wr_try(16'(16'hA000 + i), acc);
      check(acc == 1, "R3 fill accepted", acc, 1);
    end
    for (int i = 0; i < 4; i++) begin
      wr_try(16'hDEAD, acc);
      check(acc == 0 && wr_full == 1, "R3/R4 full after depth writes", wr_full, 1);
    end
    wr_stop();
    repeat (6) @(negedge rd_clk);
    for (int i = 0; i < DEPTH; i++) begin
      rd_try(acc);
      check(acc == 1, "R6 stored word readable", acc, 1);
    end
    rd_stop();
    check(rd_empty == 1, "R4/R9 empty after drain, refused writes left nothing", rd_empty, 1);
    repeat (6) @(negedge wr_clk);
    check(wr_full == 0, "R9 full released after drain", wr_full, 0);

    // read while empty (R5)
    held = rd_data;
    @(negedge rd_clk) rd_en = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge rd_clk);
      check(rd_data == held && rd_empty == 1, "R5 empty read ignored", rd_data, held);
    end
    rd_en = 0;
    wr_try(16'h5A5A, acc);
    wr_stop();
    repeat (5) @(negedge rd_clk);
    check(rd_empty == 0, "R6 empty falls with data", rd_empty, 0);
    rd_try(acc);
    rd_stop();
    check(rd_data == 16'h5A5A, "R5 next written word is next read", rd_data, 16'h5A5A);

    // streaming with shifting duty cycles (R2, R3)
    fork
      begin
        int sent = 0;
        int c = 0;
        logic a;
        while (sent < NS) begin
          logic go;
          go = (sent < 100) ? 1'b1 : (sent < 200) ? (c % 2 == 0) : (c % 5 == 0);
          if (go) begin
            wr_try(16'(sent * 7 + 3), a);
            if (a) sent++;
            check(q.size() <= DEPTH, "R3 occupancy bound", q.size(), DEPTH);
          end else begin
            @(negedge wr_clk);
            wr_en = 0;
          end
          c++;
        end
        wr_stop();
      end
      begin
        int got = 0;
        int c = 0;
        logic a;
        while (got < NS) begin
          logic go;
          go = (got < 100) ? (c % 4 == 0) : (got < 200) ? (c % 3 != 0) : 1'b1;
          if (go) begin
            rd_try(a);
            if (a) got++;
          end else begin
            @(negedge rd_clk);
            rd_cmp();
            rd_en = 0;
          end
          c++;
        end
        rd_stop();
      end
    join
    repeat (6) @(negedge rd_clk);
    check(rd_empty == 1, "R9 empty after stream", rd_empty, 1);
    check(q.size() == 0, "R2 all words delivered", q.size(), 0);
    check(wr_full == 0, "R9 full clear after stream", wr_full, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule